// File: doc/BRIEF.md
# Serial EEPROM Target with One-Time Write Lock

This block sits on a two-wire serial bus as a target and behaves like a 256-byte byte-addressed serial EEPROM. A bus controller reaches the array through a strappable 7-bit device address. The address is 0x50 plus the value on a 3-bit select input. The controller can use a one-byte word-address write, byte writes and multi-byte writes, current-address reads, random reads made with a repeated START, and sequential reads. Contents are held in registers, so writes take effect at once and there is no programming delay.

A second device address sits 0x20 below the memory address, at 0x30 plus the select value. It controls a one-time lock. While the lock is open, that address acknowledges an address-only write. Any data byte sent to it closes the lock for good. After that, the lower half of the array ignores writes and the lock address stops answering. Only the power-on reset input reopens the lock, and it also fills the array with 0xFF. The ordinary reset restarts the bus engine and leaves the lock and the array as they are.

SCL and SDA pass through a two-stage synchronizer running on a fast system clock. The block never drives SDA high: it pulls SDA low only for acknowledge bits and for read data.

Top module: `eep_target`

## Requirements
- R1: An address byte whose upper 7 bits equal 0x50 + addr_sel is acknowledged for both R/W values. Any other address that is not the open lock address gets no acknowledge, and the target then stays silent until the next START or STOP.
- R2: A write of a word-address byte followed by a data byte stores that data at the word address. A later random read (word-address write, repeated START, read address) returns it.
- R3: The word pointer advances by one after each byte written or read, and wraps from 0xFF to 0x00. This holds for multi-byte writes and for sequential reads.
- R4: A current-address read (a START directly followed by the read address) returns data from the pointer left by the previous access. Reset puts the pointer at 0x00.
- R5: While unlocked, a write-direction address byte to 0x30 + addr_sel that is followed directly by STOP is acknowledged. A read-direction address byte to that address gets no acknowledge.
- R6: While unlocked, writes to locations 0x00–0x7F are stored.
- R7: The first data byte sent to the lock address is acknowledged and sets the lock, whatever its value. From then on the lock address gets no acknowledge for any transaction, including address-only writes.
- R8: While locked, data writes to 0x00–0x7F are still acknowledged, and they leave the memory unchanged. Locations 0x80–0xFF stay writable.
- R9: Power-on reset (por) clears the lock and sets every memory byte to 0xFF. The ordinary reset (rst) changes neither the lock nor the memory.
- R10: sda_oe changes only while the synchronized SCL is low.
- R11: sda_oe is asserted only during an acknowledge bit the target gives or during a read-data bit that is 0. It is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset of the bus engine |
| por | input | 1 | Synchronous active-high power-on reset: opens the lock, fills the memory with 0xFF |
| addr_sel | input | 3 | Strap that picks the low three device-address bits |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |

## Verification
The target reacts three system clocks after each SCL falling edge: two synchronizer stages plus the engine register. The bench keeps SCL low for eight clocks before it raises it, so an acknowledge or data bit has settled before SCL rises. It samples SDA halfway through the SCL-high phase, on a falling system-clock edge. A write's effect, or the absence of one, is never read from inside the block. It is checked through a later read transaction, by comparison with a reference array that the bench updates from the requirements. The lock state is likewise observed through acknowledges at the lock address.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int AW          = 8;
    localparam int DW          = 8;
    localparam int DEPTH       = 1 << AW;
    localparam int SYNC_STAGES = 2;

    localparam logic [6:0] MEM_BASE = 7'h50;
    localparam logic [6:0] LOCK_GAP = 7'h20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WORD,
        ST_DATA,
        ST_ACK,
        ST_READ,
        ST_RACK,
        ST_SKIP
    } state_e;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_req_t;

    function automatic logic [6:0] mem_dev(input logic [2:0] sel);
        return {MEM_BASE[6:3], sel};
    endfunction

    function automatic logic [6:0] lock_dev(input logic [2:0] sel);
        return mem_dev(sel) - LOCK_GAP;
    endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int STAGES = eep_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_p;
    logic              sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_p    <= scl_pipe[STAGES-1];
            sda_p    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s    = scl_pipe[STAGES-1];
    assign sda_s    = sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/eep_mem.sv
module eep_mem
    import eep_pkg::*;
#(
    parameter int MEM_AW    = AW,
    parameter int MEM_DW    = DW,
    parameter int MEM_DEPTH = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic              por,
    input  wr_req_t           wr_i,
    input  logic              set_lock_i,
    input  logic [MEM_AW-1:0] raddr_i,
    output logic [MEM_DW-1:0] rdata_o,
    output logic              lock_o
);
    localparam logic [MEM_AW-1:0] LOCK_LIM = MEM_AW'(MEM_DEPTH / 2);

    logic [MEM_DW-1:0] mem_q [MEM_DEPTH];
    logic              lock_q;
    logic              blocked;

    assign blocked = lock_q && (wr_i.addr < LOCK_LIM);

    always_ff @(posedge clk) begin
        if (por) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '1;
            lock_q <= 1'b0;
        end else begin
            if (wr_i.we && !blocked) mem_q[wr_i.addr] <= wr_i.data;
            if (set_lock_i) lock_q <= 1'b1;
        end
    end

    assign rdata_o = mem_q[raddr_i];
    assign lock_o  = lock_q;

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (por)
        lock_q |=> lock_q);

    // R9
    por_open_chk: assert property (@(posedge clk)
        por |=> !lock_q);

    // R8
    lower_hold_chk: assert property (@(posedge clk) disable iff (por)
        (lock_q && wr_i.we && wr_i.addr < LOCK_LIM)
        |=> mem_q[$past(wr_i.addr)] == $past(mem_q[wr_i.addr]));

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    sel_i,
    input  logic          lock_i,
    input  logic [DW-1:0] rdata_i,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_ev,
    input  logic          stop_ev,
    output wr_req_t       wr_o,
    output logic          set_lock_o,
    output logic [AW-1:0] raddr_o,
    output logic          sda_oe_o
);
    state_e        state_q, nxt_q;
    logic [3:0]    cnt_q;
    logic [7:0]    shreg_q;
    logic [DW-1:0] rbyte_q;
    logic [AW-1:0] ptr_q;
    logic          ack_q, tgt_lock_q, ph_q, mack_q, oe_q;
    logic [7:0]    byte_in;
    logic          mem_hit, lock_hit;

    assign byte_in  = {shreg_q[6:0], sda_s};
    assign mem_hit  = byte_in[7:1] == mem_dev(sel_i);
    assign lock_hit = (byte_in[7:1] == lock_dev(sel_i)) && !lock_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            nxt_q      <= ST_IDLE;
            cnt_q      <= '0;
            shreg_q    <= '0;
            rbyte_q    <= '0;
            ptr_q      <= '0;
            ack_q      <= 1'b0;
            tgt_lock_q <= 1'b0;
            ph_q       <= 1'b0;
            mack_q     <= 1'b0;
            oe_q       <= 1'b0;
            wr_o       <= '0;
            set_lock_o <= 1'b0;
        end else begin
            wr_o.we    <= 1'b0;
            set_lock_o <= 1'b0;
            if (start_ev) begin
                state_q <= ST_DEV;
                cnt_q   <= '0;
                ph_q    <= 1'b0;
                oe_q    <= 1'b0;
            end else if (stop_ev) begin
                state_q <= ST_IDLE;
                ph_q    <= 1'b0;
                oe_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_DEV, ST_WORD, ST_DATA: begin
                        if (scl_rise) begin
                            shreg_q <= byte_in;
                            cnt_q   <= cnt_q + 4'd1;
                            if (cnt_q == 4'd7) begin
                                cnt_q   <= '0;
                                ph_q    <= 1'b0;
                                state_q <= ST_ACK;
                                if (state_q == ST_DEV) begin
                                    tgt_lock_q <= lock_hit;
                                    ack_q      <= mem_hit || (lock_hit && !byte_in[0]);
                                    nxt_q      <= byte_in[0] ? ST_READ :
                                                  (lock_hit ? ST_DATA : ST_WORD);
                                end else if (state_q == ST_WORD) begin
                                    ptr_q <= byte_in;
                                    ack_q <= 1'b1;
                                    nxt_q <= ST_DATA;
                                end else if (tgt_lock_q) begin
                                    set_lock_o <= !lock_i;
                                    ack_q      <= !lock_i;
                                    nxt_q      <= ST_DATA;
                                end else begin
                                    wr_o  <= '{we: 1'b1, addr: ptr_q, data: byte_in};
                                    ptr_q <= ptr_q + 1'b1;
                                    ack_q <= 1'b1;
                                    nxt_q <= ST_DATA;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!ph_q) begin
                                oe_q <= ack_q;
                                ph_q <= 1'b1;
                            end else begin
                                ph_q <= 1'b0;
                                oe_q <= 1'b0;
                                if (!ack_q) begin
                                    state_q <= ST_SKIP;
                                end else if (nxt_q == ST_READ) begin
                                    rbyte_q <= rdata_i;
                                    ptr_q   <= ptr_q + 1'b1;
                                    oe_q    <= ~rdata_i[DW-1];
                                    cnt_q   <= 4'd1;
                                    state_q <= ST_READ;
                                end else begin
                                    state_q <= nxt_q;
                                end
                            end
                        end
                    end
                    ST_READ: begin
                        if (scl_fall) begin
                            if (cnt_q < 4'd8) begin
                                oe_q    <= ~rbyte_q[DW-2];
                                rbyte_q <= rbyte_q << 1;
                                cnt_q   <= cnt_q + 4'd1;
                            end else begin
                                oe_q    <= 1'b0;
                                state_q <= ST_RACK;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mack_q <= ~sda_s;
                        if (scl_fall) begin
                            if (mack_q) begin
                                rbyte_q <= rdata_i;
                                ptr_q   <= ptr_q + 1'b1;
                                oe_q    <= ~rdata_i[DW-1];
                                cnt_q   <= 4'd1;
                                state_q <= ST_READ;
                            end else begin
                                state_q <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign raddr_o  = ptr_q;
    assign sda_oe_o = oe_q;

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_q != $past(oe_q)) |-> !scl_s);

    // R11
    oe_phase_chk: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> (state_q == ST_ACK || state_q == ST_READ));

endmodule

// File: rtl/eep_target.sv
module eep_target
    import eep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic [2:0] addr_sel,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe
);
    logic          eng_rst;
    logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    wr_req_t       wr;
    logic          set_lock, lock;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata;

    assign eng_rst = rst | por;

    eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (eng_rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    eep_ctrl u_ctrl (
        .clk        (clk),
        .rst        (eng_rst),
        .sel_i      (addr_sel),
        .lock_i     (lock),
        .rdata_i    (rdata),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .wr_o       (wr),
        .set_lock_o (set_lock),
        .raddr_o    (raddr),
        .sda_oe_o   (sda_oe)
    );

    eep_mem #(.MEM_AW(AW), .MEM_DW(DW), .MEM_DEPTH(DEPTH)) u_mem (
        .clk        (clk),
        .por        (por),
        .wr_i       (wr),
        .set_lock_i (set_lock),
        .raddr_i    (raddr),
        .rdata_o    (rdata),
        .lock_o     (lock)
    );

endmodule

// File: tb/eep_target_bench.sv
module eep_target_bench;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por = 1'b1;
    logic [2:0] sel_b = 3'd5;
    logic       m_scl = 1'b1;
    logic       m_sda_low = 1'b0;
    logic       sda_oe;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mem_ref [256];
    logic [7:0] wbuf [4];
    logic [7:0] ptr_ref;
    bit         lock_ref;

    always #2.5 clk = ~clk;

    assign sda_line = !(m_sda_low || sda_oe);

    eep_target u_eep_target (
        .clk      (clk),
        .rst      (rst),
        .por      (por),
        .addr_sel (sel_b),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe)
    );

    function automatic logic [6:0] mem_a();
        return {4'b1010, sel_b};
    endfunction

    function automatic logic [6:0] lock_a();
        return {4'b0110, sel_b};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ref_write(input logic [7:0] a, input logic [7:0] d);
        if (!(lock_ref && a < 8'h80)) mem_ref[a] = d;
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wq(Q);
        m_scl = 1'b1;     wq(Q);
        m_sda_low = 1'b1; wq(Q);
        m_scl = 1'b0;     wq(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wq(Q);
        m_scl = 1'b1;     wq(Q);
        m_sda_low = 1'b0; wq(2 * Q);
    endtask

    task automatic send_bit(input bit b);
        m_sda_low = !b; wq(Q);
        m_scl = 1'b1;   wq(Q);
        m_scl = 1'b0;   wq(Q);
    endtask

    task automatic get_bit(output bit b);
        m_sda_low = 1'b0; wq(Q);
        m_scl = 1'b1;     wq(Q / 2);
        b = sda_line;     wq(Q / 2);
        m_scl = 1'b0;     wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit more);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        send_bit(!more);
    endtask

    task automatic tx_quick(input logic [6:0] dev, input bit exp, input string req);
        bit a;
        bus_start();
        send_byte({dev, 1'b0}, a);
        chk(a == exp, req, a, exp);
        bus_stop();
    endtask

    task automatic tx_read_nack(input logic [6:0] dev, input string req);
        bit a;
        bus_start();
        send_byte({dev, 1'b1}, a);
        chk(!a, req, a, 0);
        bus_stop();
    endtask

    task automatic tx_write(input logic [7:0] wa, input int n, input string req);
        bit a;
        bus_start();
        send_byte({mem_a(), 1'b0}, a);
        chk(a, req, a, 1);
        send_byte(wa, a);
        chk(a, req, a, 1);
        ptr_ref = wa;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            chk(a, req, a, 1);
            ref_write(ptr_ref, wbuf[i]);
            ptr_ref++;
        end
        bus_stop();
    endtask

    task automatic read_body(input int n, input string req);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            recv_byte(d, i < n - 1);
            chk(d == mem_ref[ptr_ref], req, d, mem_ref[ptr_ref]);
            ptr_ref++;
        end
        bus_stop();
    endtask

    task automatic tx_rand_read(input logic [7:0] wa, input int n, input string req);
        bit a;
        bus_start();
        send_byte({mem_a(), 1'b0}, a);
        send_byte(wa, a);
        ptr_ref = wa;
        bus_start();
        send_byte({mem_a(), 1'b1}, a);
        chk(a, req, a, 1);
        read_body(n, req);
    endtask

    task automatic tx_cur_read(input int n, input string req);
        bit a;
        bus_start();
        send_byte({mem_a(), 1'b1}, a);
        chk(a, req, a, 1);
        read_body(n, req);
    endtask

    task automatic tx_lock_byte(input logic [7:0] d, input string req);
        bit a;
        bus_start();
        send_byte({lock_a(), 1'b0}, a);
        chk(a == !lock_ref, req, a, !lock_ref);
        if (a) begin
            send_byte(d, a);
            chk(a, req, a, 1);
            lock_ref = 1'b1;
        end
        bus_stop();
    endtask

    task automatic random_pass(input int iters, input string req);
        logic [7:0] wa;
        int n;
        for (int k = 0; k < iters; k++) begin
            wa = 8'($urandom);
            n  = 1 + int'($urandom % 3);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            tx_write(wa, n, req);
            tx_rand_read(wa, n, req);
        end
    endtask

    task automatic do_por();
        @(negedge clk); por = 1'b1; wq(4); por = 1'b0; wq(4);
        for (int i = 0; i < 256; i++) mem_ref[i] = 8'hFF;
        lock_ref = 1'b0;
        ptr_ref  = 8'h00;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 256; i++) mem_ref[i] = 8'hFF;
        lock_ref = 1'b0;
        ptr_ref  = 8'h00;
        wq(6);
        por = 1'b0; rst = 1'b0;
        wq(6);

        // R11: idle after reset
        chk(sda_oe == 1'b0, "R11 reset", sda_oe, 0);
        // R9 / R4: erased contents read from pointer 0
        tx_cur_read(2, "R9 R4 erased");

        // R1
        tx_quick(mem_a(), 1'b1, "R1 own address");
        tx_quick({4'b1010, 3'd2}, 1'b0, "R1 other select");
        tx_quick(7'h21, 1'b0, "R1 foreign");
        sel_b = 3'd2;
        tx_quick(mem_a(), 1'b1, "R1 new select");

        // R2
        wbuf[0] = 8'hA5;
        tx_write(8'h90, 1, "R2 write");
        tx_rand_read(8'h90, 1, "R2 read");
        // R4: pointer continues
        tx_cur_read(2, "R4 current");

        // R6 / R3
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        tx_write(8'h10, 4, "R6 lower write");
        tx_rand_read(8'h10, 4, "R6 R3 sequential");
        wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
        tx_write(8'hFF, 2, "R3 write wrap");
        tx_rand_read(8'hFE, 3, "R3 read wrap");

        random_pass(12, "R2 R3 random");

        // R5
        tx_quick(lock_a(), 1'b1, "R5 quick");
        tx_read_nack(lock_a(), "R5 read");

        // R7
        tx_lock_byte(8'h00, "R7 lock");
        tx_quick(lock_a(), 1'b0, "R7 after lock");
        tx_lock_byte(8'h5A, "R7 retry");
        tx_quick(mem_a(), 1'b1, "R7 memory live");

        // R8
        wbuf[0] = 8'h55; wbuf[1] = 8'h66;
        tx_write(8'h10, 2, "R8 lower");
        tx_rand_read(8'h10, 2, "R8 lower hold");
        wbuf[0] = 8'h77;
        tx_write(8'hA0, 1, "R8 upper");
        tx_rand_read(8'hA0, 1, "R8 upper stored");
        wbuf[0] = 8'h99; wbuf[1] = 8'h98;
        tx_write(8'h7F, 2, "R8 boundary");
        tx_rand_read(8'h7F, 2, "R8 boundary read");
        random_pass(6, "R8 random");

        // R9: ordinary reset keeps lock and data
        @(negedge clk); rst = 1'b1; wq(4); rst = 1'b0; wq(4);
        ptr_ref = 8'h00;
        tx_quick(lock_a(), 1'b0, "R9 rst keeps lock");
        tx_cur_read(1, "R9 R4 rst pointer");
        tx_rand_read(8'h10, 2, "R9 rst keeps data");

        // R9: power-on reset reopens
        do_por();
        tx_quick(lock_a(), 1'b1, "R9 por unlock");
        tx_rand_read(8'h10, 2, "R9 por erase");
        wbuf[0] = 8'h42;
        tx_write(8'h05, 1, "R9 R6 writable");
        tx_rand_read(8'h05, 1, "R9 R6 readback");

        done = 1'b1;
        summary();
    end

endmodule